// File: doc/BRIEF.md
# Bus Hold Request Handshake

This block lets a bus master outside the chip take over the system bus. An external device pulls the active-low request input low to ask for the bus. The block first synchronizes that input to the core clock. It then tells the bus cycle controller to stop launching new transfers. Any transfer already under way is allowed to run to its final acknowledge. After that, the block drops a single output-enable that the pad ring applies to every bus-interface pin: address, data, chip selects, read, write and byte-lane strobes. The active-low acknowledge goes low as soon as the request is accepted, which can be earlier than the moment the pins actually float. Pins outside the bus interface are not affected by this block.

When the external master lets the request go high again, the block drives the bus pins once more and raises the acknowledge. One core cycle later it lets the cycle controller launch internal transfers again. A transfer counts as launched when `int_req` is high in a cycle where `req_stall` is low. It counts as finished when `cyc_last_ack` is high. The controller never raises `cyc_last_ack` in the same cycle that it launches a transfer.

Top module: `bus_hold_ctrl`

## Requirements
- R1: During and right after reset, `hold_ack_n` is 1, `bus_oe` is 1 (pins driven) and `req_stall` is 0.
- R2: `hold_req_n` passes through a two-flop synchronizer. A level presented before rising edge k reaches `hold_ack_n` at edge k+2 and not earlier. The same latency applies in both directions.
- R3: If no transfer is open when the request is accepted, `hold_ack_n` and `bus_oe` both go to 0 on the same edge. Both stay at 0 for as long as the request stays low.
- R4: If a transfer is open when the request is accepted, `hold_ack_n` goes to 0 at acceptance but `bus_oe` stays 1. `bus_oe` goes to 0 on the edge after the cycle in which `cyc_last_ack` is 1.
- R5: A transfer launched in the acceptance cycle itself (`int_req` high while `req_stall` is still 0) is also allowed to complete before `bus_oe` goes to 0.
- R6: `req_stall` is 1 whenever `hold_ack_n` is 0, and 0 during normal operation.
- R7: On release, `hold_ack_n` and `bus_oe` return to 1 on the same edge while `req_stall` is still 1. `req_stall` returns to 0 one cycle later.
- R8: `bus_oe` is never 0 unless `hold_ack_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| hold_req_n | input | 1 | Asynchronous hold request from the external master, active low |
| int_req | input | 1 | Internal transfer request from the cycle controller; launches a transfer when `req_stall` is 0 |
| cyc_last_ack | input | 1 | Final acknowledge of the open transfer |
| hold_ack_n | output | 1 | Hold acknowledge, active low |
| bus_oe | output | 1 | 1 = the pad ring drives the bus-interface pins, 0 = the pins are high impedance |
| req_stall | output | 1 | 1 = the cycle controller must not launch a new transfer |

## Verification
Four ordering rules are checked by the assertions on every cycle:
- The pins never float without the acknowledge low (R8).
- The acknowledge low always implies the stall (R6).
- Pins and acknowledge come back together while the stall is still held (R7).
- An open transfer always keeps the pins driven (R4).

Some behaviour can only be shown by the bench's scenarios:
- The exact synchronizer latency.
- That a transfer launched in the acceptance cycle is drained.
- That the hold persists for as long as the request is held.

A cycle-level model in the bench also follows random request toggling against randomly sized transfers.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    HS_OWN    = 2'd0,
    HS_DRAIN  = 2'd1,
    HS_FLOAT  = 2'd2,
    HS_RETURN = 2'd3
  } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/hold_cyc_track.sv
module hold_cyc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic last_ack,
  output logic open_o
);
  logic open_q, open_d;

  always_comb begin
    open_d = open_q;
    if (launch)        open_d = 1'b1;
    else if (last_ack) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign open_o = open_q;
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_want,
  input  logic cyc_pending,
  input  logic cyc_end,
  output logic ack_n_o,
  output logic oe_o,
  output logic stall_o
);
  hold_state_e st_q, st_d;
  logic ack_n_q, oe_q, stall_q;
  logic ack_n_d, oe_d, stall_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_OWN:    if (hold_want) st_d = cyc_pending ? HS_DRAIN : HS_FLOAT;
      HS_DRAIN:  if (cyc_end)   st_d = HS_FLOAT;
      HS_FLOAT:  if (!hold_want) st_d = HS_RETURN;
      HS_RETURN: st_d = HS_OWN;
      default:   st_d = HS_OWN;
    endcase
  end

  // Outputs registered from the next state: glitch-free pins, same latency
  always_comb begin
    ack_n_d = !((st_d == HS_DRAIN) || (st_d == HS_FLOAT));
    oe_d    = (st_d != HS_FLOAT);
    stall_d = (st_d != HS_OWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= HS_OWN;
      ack_n_q <= 1'b1;
      oe_q    <= 1'b1;
      stall_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ack_n_q <= ack_n_d;
      oe_q    <= oe_d;
      stall_q <= stall_d;
    end
  end

  assign ack_n_o = ack_n_q;
  assign oe_o    = oe_q;
  assign stall_o = stall_q;

  assert_float_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> !ack_n_q);

  assert_ack_implies_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_q |-> stall_q);

  assert_return_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n_q) |-> (oe_q && stall_q));

  assert_stall_drops_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_q) |-> ($past(oe_q) && $past(ack_n_q)));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic int_req,
  input  logic cyc_last_ack,
  output logic hold_ack_n,
  output logic bus_oe,
  output logic req_stall
);
  logic req_n_sync;
  logic launch;
  logic cyc_open;
  logic cyc_pending;

  hold_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (hold_req_n),
    .q     (req_n_sync)
  );

  assign launch = int_req && !req_stall;

  hold_cyc_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .last_ack (cyc_last_ack),
    .open_o   (cyc_open)
  );

  // A transfer launched this very cycle also has to drain
  assign cyc_pending = (cyc_open && !cyc_last_ack) || launch;

  hold_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_want   (!req_n_sync),
    .cyc_pending (cyc_pending),
    .cyc_end     (cyc_last_ack),
    .ack_n_o     (hold_ack_n),
    .oe_o        (bus_oe),
    .stall_o     (req_stall)
  );

  assert_open_keeps_pins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_open && !cyc_last_ack) |-> bus_oe);
endmodule

// File: tb/bus_hold_ctrl_test.sv
module bus_hold_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic hold_req_n, int_req, cyc_last_ack;
  logic hold_ack_n, bus_oe, req_stall;

  always #5 clk = ~clk;

  bus_hold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .int_req(int_req),
    .cyc_last_ack(cyc_last_ack), .hold_ack_n(hold_ack_n), .bus_oe(bus_oe),
    .req_stall(req_stall)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit auto_mode = 0;
  bit cmp_en = 0;

  // Reference model: 0 normal, 1 draining, 2 floating, 3 returning
  logic m_s1, m_s2;
  int   m_st;
  logic b_open;
  int   b_rem;
  logic m_launch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_st <= 0; b_open <= 1'b0; b_rem <= 0;
    end else begin
      m_launch = int_req && (m_st == 0);
      m_s1 <= hold_req_n;
      m_s2 <= m_s1;
      case (m_st)
        0: if (!m_s2) m_st <= ((b_open && !cyc_last_ack) || m_launch) ? 1 : 2;
        1: if (cyc_last_ack) m_st <= 2;
        2: if (m_s2) m_st <= 3;
        default: m_st <= 0;
      endcase
      if (m_launch) begin b_open <= 1'b1; b_rem <= int'($urandom_range(0, 3)); end
      else if (cyc_last_ack) b_open <= 1'b0;
      else if (b_open && b_rem > 0) b_rem <= b_rem - 1;
    end
  end

  function automatic logic exp_ack_n(int st); return !(st == 1 || st == 2); endfunction
  function automatic logic exp_oe(int st);    return st != 2;               endfunction
  function automatic logic exp_stall(int st); return st != 0;               endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 hold_ack_n vs model", hold_ack_n, exp_ack_n(m_st));
      chk("R4 bus_oe vs model", bus_oe, exp_oe(m_st));
      chk("R6 req_stall vs model", req_stall, exp_stall(m_st));
      if (!bus_oe) chk("R8 float without ack", hold_ack_n, 1'b0);
    end
  end

  // Random stimulus: request toggles, transfers of random length
  always @(negedge clk) begin
    if (auto_mode) begin
      if ($urandom_range(0, 15) == 0) hold_req_n <= ~hold_req_n;
      int_req      <= !b_open && ($urandom_range(0, 2) == 0);
      cyc_last_ack <= b_open && (b_rem == 0);
    end
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    hold_req_n = 1'b1; int_req = 1'b0; cyc_last_ack = 1'b0; rst_n = 1'b0;
    step(3);
    chk("R1 ack during reset", hold_ack_n, 1'b1);
    chk("R1 oe during reset", bus_oe, 1'b1);
    chk("R1 stall during reset", req_stall, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 ack after reset", hold_ack_n, 1'b1);
    chk("R1 stall after reset", req_stall, 1'b0);
    cmp_en = 1;

    // R2 / R3: idle bus, synchronizer latency
    hold_req_n = 1'b0;
    step(2);
    chk("R2 ack not before 3rd edge", hold_ack_n, 1'b1);
    step(1);
    chk("R2 ack on 3rd edge", hold_ack_n, 1'b0);
    chk("R3 idle bus floats with ack", bus_oe, 1'b0);
    step(10);
    chk("R3 hold persists ack", hold_ack_n, 1'b0);
    chk("R3 hold persists oe", bus_oe, 1'b0);
    chk("R6 stall in hold", req_stall, 1'b1);

    // R7: release
    hold_req_n = 1'b1;
    step(2);
    chk("R2 release latency ack", hold_ack_n, 1'b0);
    step(1);
    chk("R7 ack back", hold_ack_n, 1'b1);
    chk("R7 oe back", bus_oe, 1'b1);
    chk("R7 stall still held", req_stall, 1'b1);
    step(1);
    chk("R7 stall released", req_stall, 1'b0);
    step(3);

    // R4: transfer already open when request arrives
    int_req = 1'b1;
    step(1);
    int_req = 1'b0;
    hold_req_n = 1'b0;
    step(3);
    chk("R4 ack low at accept", hold_ack_n, 1'b0);
    chk("R4 pins still driven", bus_oe, 1'b1);
    step(4);
    chk("R4 pins driven while open", bus_oe, 1'b1);
    cyc_last_ack = 1'b1;
    step(1);
    cyc_last_ack = 1'b0;
    chk("R4 float after last ack", bus_oe, 1'b0);
    hold_req_n = 1'b1;
    step(6);

    // R5: transfer launched in the acceptance cycle
    hold_req_n = 1'b0;
    step(2);
    chk("R5 not yet stalled", req_stall, 1'b0);
    int_req = 1'b1;
    step(1);
    int_req = 1'b0;
    chk("R5 ack low", hold_ack_n, 1'b0);
    chk("R5 pins driven for new transfer", bus_oe, 1'b1);
    step(2);
    chk("R5 pins still driven", bus_oe, 1'b1);
    cyc_last_ack = 1'b1;
    step(1);
    cyc_last_ack = 1'b0;
    chk("R5 float after its last ack", bus_oe, 1'b0);
    hold_req_n = 1'b1;
    step(6);

    // Random phase
    auto_mode = 1;
    step(4000);
    auto_mode = 0;
    hold_req_n = 1'b1; int_req = 1'b0;
    cyc_last_ack = b_open;
    step(1);
    cyc_last_ack = 1'b0;
    step(8);
    chk("R7 idle after random phase", req_stall, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule